// File: doc/BRIEF.md
# Host Interrupt Enable Latch

This block is one control-register slice of a host-side serial interrupt source. It holds two enable bits, one for host interrupt line 11 and one for line 10. Both bits are tied to the output-buffer-full flag of one data channel. A local CPU reads and writes the slice through an 8-bit register port. Each bit drives a registered request output toward the serial interrupt encoder, which lies outside this block.

A mode input chooses how the requests are formed. In flag-gated mode (mode 0), a request follows the buffer-full flag gated by its enable bit, and clearing the flag also drops both enables. In direct mode (mode 1), a set enable bit raises its request by itself.

An enable bit is set under a guard. Writing 1 sets the bit only when a read of that bit has returned 0 since the last write to the register. A per-bit arm flag records this. Interface hardware reset and interface software reset both clear the enables.

Top module: `host_irq_enable_latch`

## Requirements
- R1: After system reset, both enable bits are 0, the read data is 0x00, and both request outputs are 0.
- R2: Register layout: bit 7 holds the line-11 enable and bit 6 holds the line-10 enable. Bits 5 to 0 always read 0, and writes to them have no effect.
- R3: Writing 0 to an enable bit clears that bit on the clock edge of the write.
- R4: Writing 1 sets an enable bit only if a read since the last register write returned 0 for that bit. Any write disarms both bits. A write of 1 without arming leaves the bit unchanged. When a read and a write fall in the same cycle, the write governs the arm flags.
- R5: An interface hardware reset pulse clears both enable bits. An interface software reset pulse does the same.
- R6: In mode 0, a buffer-flag clear event clears both enable bits. In mode 1, the clear event has no effect on the enable bits.
- R7: In mode 0, each request output equals the buffer-full flag AND its enable bit, both taken from the previous cycle.
- R8: In mode 1, each request output equals its enable bit from the previous cycle, whatever the buffer-full flag is.
- R9: If a reset, or a mode-0 buffer-flag clear, arrives in the same cycle as an armed write of 1, the bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| if_hw_rst | input | 1 | Interface hardware reset pulse, synchronous |
| if_sw_rst | input | 1 | Interface software reset pulse, synchronous |
| reg_rd | input | 1 | CPU read strobe for this register |
| reg_wr | input | 1 | CPU write strobe for this register |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Read data: {line-11 enable, line-10 enable, 6'b0} |
| obuf_full | input | 1 | Output-buffer-full flag of the data channel |
| obuf_clr | input | 1 | One-cycle pulse when the buffer-full flag is cleared |
| direct_mode | input | 1 | 0 = flag-gated requests, 1 = enable drives request |
| req_l11 | output | 1 | Host interrupt line 11 request |
| req_l10 | output | 1 | Host interrupt line 10 request |

## Verification
Read data is combinational from the enable bits, so a write, reset or clear event shows up on reg_rdata right after the clock edge that takes it. The request outputs pass through one more register and appear one edge later, formed from the enable and flag values of the cycle before. The bench drives each stimulus on a falling edge. For that cycle it queues one expected pair: the read data after the edge, and the request value computed from the model state before the edge. A monitor compares the pair 5 ns after the rising edge. That way each result is checked in exactly the cycle it is due.

// File: rtl/host_irq_enable_latch.sv
module host_irq_enable_latch #(
  parameter int DW   = 8,
  parameter int B_11 = 7,
  parameter int B_10 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_hw_rst,
  input  logic          if_sw_rst,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          obuf_full,
  input  logic          obuf_clr,
  input  logic          direct_mode,
  output logic          req_l11,
  output logic          req_l10
);

  logic [1:0] en, arm, req;
  logic [1:0] wbit;
  logic       kill;

  assign wbit = {reg_wdata[B_11], reg_wdata[B_10]};
  assign kill = if_hw_rst | if_sw_rst | (!direct_mode & obuf_clr);

  always_comb begin
    reg_rdata       = '0;
    reg_rdata[B_11] = en[1];
    reg_rdata[B_10] = en[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      arm <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (kill)
          en[i] <= 1'b0;
        else if (reg_wr)
          en[i] <= wbit[i] ? (en[i] | arm[i]) : 1'b0;
      end
      if (if_hw_rst | if_sw_rst | reg_wr)
        arm <= '0;
      else if (reg_rd)
        arm <= arm | ~en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= '0;
    else        req <= direct_mode ? en : (en & {2{obuf_full}});
  end

  assign req_l11 = req[1];
  assign req_l10 = req[0];

  // R4
  set11_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en[1]) |-> $past(reg_wr && arm[1] && reg_wdata[B_11]));
  // R4
  set10_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en[0]) |-> $past(reg_wr && arm[0] && reg_wdata[B_10]));
  // R5
  if_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_hw_rst || if_sw_rst) |=> (reg_rdata[B_11] == 1'b0 && reg_rdata[B_10] == 1'b0));
  // R6
  flag_clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_mode && obuf_clr) |=> (reg_rdata[B_11] == 1'b0 && reg_rdata[B_10] == 1'b0));
  // R3
  write_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[B_11]) |=> !reg_rdata[B_11]);
  // R7
  gated_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_mode && !obuf_full) |=> (!req_l11 && !req_l10));
  // R8
  direct_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_mode && reg_rdata[B_11]) |=> req_l11);

endmodule

// File: tb/host_irq_enable_latch_tb.sv
module host_irq_enable_latch_tb;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       if_hw_rst = 0, if_sw_rst = 0;
  logic       reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       obuf_full = 0, obuf_clr = 0, direct_mode = 0;
  logic       req_l11, req_l10;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] rd;
    logic [1:0] rq;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_en = '0, m_arm = '0;

  always #10 clk = ~clk;

  host_irq_enable_latch u_dut (
    .clk(clk), .rst_n(rst_n), .if_hw_rst(if_hw_rst), .if_sw_rst(if_sw_rst),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .obuf_full(obuf_full), .obuf_clr(obuf_clr), .direct_mode(direct_mode),
    .req_l11(req_l11), .req_l10(req_l10)
  );

  task automatic step(input bit rd, input bit wr, input logic [7:0] wd,
                      input bit full, input bit clr, input bit mode,
                      input bit hw, input bit sw, input string tag);
    exp_t e;
    logic [1:0] nen, narm, wb;
    reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    obuf_full = full; obuf_clr = clr; direct_mode = mode;
    if_hw_rst = hw; if_sw_rst = sw;
    wb = {wd[7], wd[6]};
    e.rq = mode ? m_en : (m_en & {2{full}});
    nen = m_en;
    if (hw || sw || (!mode && clr)) nen = 2'b00;
    else if (wr) nen = (wb & (m_en | m_arm));
    narm = m_arm;
    if (hw || sw || wr) narm = 2'b00;
    else if (rd) narm = m_arm | ~m_en;
    m_en = nen; m_arm = narm;
    e.rd = {nen, 6'b0};
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input bit full, input bit mode, input string tag);
    step(0, 0, 8'h00, full, 0, mode, 0, 0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (reg_rdata !== e.rd || {req_l11, req_l10} !== e.rq) begin
          n_fail++;
          $display("FAIL %s: rdata=%h req=%b expected rdata=%h req=%b",
                   e.tag, reg_rdata, {req_l11, req_l10}, e.rd, e.rq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle(0, 0, "R1 reset state");
    idle(0, 0, "R1 reset state held");
    step(0, 1, 8'hFF, 0, 0, 0, 0, 0, "R4 unarmed write of 1 ignored");
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, "R4 read arms");
    step(0, 1, 8'hC0, 0, 0, 0, 0, 0, "R4 armed write sets both");
    step(0, 1, 8'hFF, 0, 0, 0, 0, 0, "R2 low bits read 0 and ignore writes");
    idle(1, 0, "R7 gated request rises with flag");
    idle(1, 0, "R7 gated request held");
    idle(0, 0, "R7 flag low drops request");
    step(0, 1, 8'h40, 1, 0, 0, 0, 0, "R3 write 0 clears line 11");
    idle(1, 0, "R7 only line 10 requests");
    step(0, 0, 8'h00, 1, 1, 0, 0, 0, "R6 mode 0 flag clear drops enables");
    idle(1, 0, "R6 enables stay cleared");
    step(1, 0, 8'h00, 0, 0, 1, 0, 0, "R8 read arms in direct mode");
    step(0, 1, 8'h80, 0, 0, 1, 0, 0, "R8 set line 11 in direct mode");
    idle(0, 1, "R8 direct request without flag");
    step(0, 0, 8'h00, 0, 1, 1, 0, 0, "R6 flag clear ignored in mode 1");
    idle(1, 1, "R8 direct request held");
    step(1, 1, 8'hC0, 0, 0, 1, 0, 0, "R4 read with write does not arm");
    step(0, 1, 8'hC0, 0, 0, 1, 0, 0, "R4 line 10 stays clear");
    step(0, 0, 8'h00, 0, 0, 1, 1, 0, "R5 hardware reset clears");
    step(1, 0, 8'h00, 0, 0, 1, 0, 0, "R5 rearm");
    step(0, 1, 8'hC0, 0, 0, 1, 0, 0, "R5 set both");
    step(0, 0, 8'h00, 0, 0, 1, 0, 1, "R5 software reset clears");
    idle(0, 1, "R5 requests drop");
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, "R9 arm");
    step(0, 1, 8'hC0, 0, 1, 0, 0, 0, "R9 flag clear beats set");
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, "R9 rearm");
    step(0, 1, 8'hC0, 0, 0, 0, 0, 1, "R9 reset beats set");
    idle(0, 0, "R9 final");
    idle(0, 0, "drain");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule